// File: doc/BRIEF.md
# Floating-Point Register Stack Manager

This block holds the eight 80-bit registers of a stack-organised floating-point unit. It also holds a 3-bit top-of-stack pointer and a 2-bit tag for each physical register. Each tag is one of: 00 valid, 01 zero, 10 special, 11 empty. Arithmetic, format conversion and memory traffic live elsewhere. This block only moves the pointer, writes, swaps and frees registers, and reports stack overflow and underflow.

Commands arrive one per cycle on `cmd_valid`/`cmd_op`. `cmd_idx` selects the logical register ST(i), and `cmd_data` carries a pushed value. A push that meets a memory fault is presented with `cmd_fault` high in the same cycle, and is then dropped. A side port (`peek_idx`) shows the data and tag of any logical register combinationally. Status-word and tag-word reads return their value on `rd_word` in the cycle after the command.

The status word holds:
- the top pointer in bits [13:11];
- a sticky invalid-operation bit in bits 0 and 7;
- a sticky stack-fault bit in bit 6;
- the stack-direction bit in bit 9.

All other bits read 0.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset, and after INIT (opcode 11), the top pointer is 0, every tag is 11 (tag word 16'hFFFF) and bits 0, 6, 7 and 9 of the status word are 0. Register data is not cleared by INIT.
- R2: Logical register ST(i) is physical register (top + i) mod 8, as seen on `peek_data`/`peek_tag`.
- R3: PUSH (opcode 1) decrements the top pointer, writes `cmd_data` into the new top register and sets its tag to 00. If that register's tag was not 11, the push still happens and also raises overflow: `stk_overflow` pulses in the next cycle and status bits 0, 6, 7 and 9 become 1.
- R4: POP (opcode 2) sets the tag of ST(0) to 11 and increments the top pointer. If that tag was already 11, the pop raises underflow: `stk_underflow` pulses in the next cycle, status bits 0, 6 and 7 become 1 and bit 9 becomes 0.
- R5: A PUSH with `cmd_fault` high leaves the pointer, the tags, the data and the status word unchanged, and raises no overflow.
- R6: POP2 (opcode 3) with `cmd_idx` = 1 pops twice. It raises underflow if either ST(0) or ST(1) was empty. With any other index it changes nothing and `cmd_unhandled` pulses in the next cycle.
- R7: XCHG (opcode 4) swaps the data and the tags of ST(0) and ST(i).
- R8: FREE (opcode 5) sets the tag of ST(i) to 11 and leaves the pointer alone. FREEP (opcode 6) does the same, then pops once without an underflow check.
- R9: INC (opcode 7) and DEC (opcode 8) change the top pointer by +1 and -1 modulo 8, and leave tags and data unchanged.
- R10: RDSW (opcode 9) returns the status word on `rd_word` with `rd_valid` high in the next cycle. Its bits [13:11] always hold the top pointer left by all earlier commands.
- R11: RDTW (opcode 10) returns the tag word, with the tag of physical register i in bits [2i+1:2i].
- R12: Opcodes 12 to 15 change no state and pulse `cmd_unhandled`. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | 3 | Logical register index i |
| cmd_data | input | 80 | Value to push |
| cmd_fault | input | 1 | Cancels a push in the same cycle |
| peek_idx | input | 3 | Logical register to observe |
| peek_data | output | 80 | Data of ST(peek_idx) |
| peek_tag | output | 2 | Tag of ST(peek_idx) |
| rd_word | output | 16 | Status or tag word from a read command |
| rd_valid | output | 1 | `rd_word` is valid this cycle |
| stk_overflow | output | 1 | Push overflowed, one-cycle pulse |
| stk_underflow | output | 1 | Pop underflowed, one-cycle pulse |
| cmd_unhandled | output | 1 | Command rejected, one-cycle pulse |

## Verification
Two functions can meet in one cycle: the fault cancel and overflow detection. A push that arrives with a fault onto a full stack exercises both. The bench provokes this after filling all eight registers. It then expects no overflow pulse and an unchanged pointer, tag word and status word, so the cancel must win.

A second meeting point is the status read that follows an overflowing push. That read must already show the new pointer and the sticky fault bits. The bench compares every command's outcome with an arithmetic model of the pointer, the eight tags and the eight data words. It sweeps every logical index for exchange, free and double pop, and wraps the pointer in both directions.

// File: rtl/fp_reg_stack.sv
`timescale 1ns/1ps
module fp_reg_stack #(
  parameter int DW = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [2:0]    cmd_idx,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_fault,
  input  logic [2:0]    peek_idx,
  output logic [DW-1:0] peek_data,
  output logic [1:0]    peek_tag,
  output logic [15:0]   rd_word,
  output logic          rd_valid,
  output logic          stk_overflow,
  output logic          stk_underflow,
  output logic          cmd_unhandled
);
  localparam int NREG = 8;
  localparam int PW   = $clog2(NREG);
  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_PUSH = 4'd1;
  localparam logic [3:0] OP_POP  = 4'd2;
  localparam logic [3:0] OP_POP2 = 4'd3;
  localparam logic [3:0] OP_XCHG = 4'd4;
  localparam logic [3:0] OP_FREE = 4'd5;
  localparam logic [3:0] OP_FREP = 4'd6;
  localparam logic [3:0] OP_INC  = 4'd7;
  localparam logic [3:0] OP_DEC  = 4'd8;
  localparam logic [3:0] OP_RDSW = 4'd9;
  localparam logic [3:0] OP_RDTW = 4'd10;
  localparam logic [3:0] OP_INIT = 4'd11;

  logic [PW-1:0] top;
  logic [1:0]    tg [NREG];
  logic [DW-1:0] dr [NREG];
  logic          ie, sf, c1;

  logic [PW-1:0] top_m1, top_p1, top_p2, sel;
  logic [15:0]   sw, tw;

  assign top_m1 = top - 1'b1;
  assign top_p1 = top + 1'b1;
  assign top_p2 = top + 2'd2;
  assign sel    = top + cmd_idx;

  assign sw = {2'b00, top, 1'b0, c1, 1'b0, ie, sf, 5'b00000, ie};

  for (genvar g = 0; g < NREG; g++) begin : g_tw
    assign tw[2*g +: 2] = tg[g];
  end

  assign peek_data = dr[top + peek_idx];
  assign peek_tag  = tg[top + peek_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top <= '0;
      ie <= 1'b0; sf <= 1'b0; c1 <= 1'b0;
      for (int k = 0; k < NREG; k++) begin
        tg[k] <= TAG_EMPTY;
        dr[k] <= '0;
      end
      rd_word <= '0; rd_valid <= 1'b0;
      stk_overflow <= 1'b0; stk_underflow <= 1'b0; cmd_unhandled <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      stk_overflow <= 1'b0;
      stk_underflow <= 1'b0;
      cmd_unhandled <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_NOP: ;
          OP_PUSH: if (!cmd_fault) begin
            top <= top_m1;
            dr[top_m1] <= cmd_data;
            tg[top_m1] <= TAG_VALID;
            if (tg[top_m1] != TAG_EMPTY) begin
              stk_overflow <= 1'b1;
              ie <= 1'b1; sf <= 1'b1; c1 <= 1'b1;
            end
          end
          OP_POP: begin
            tg[top] <= TAG_EMPTY;
            top <= top_p1;
            if (tg[top] == TAG_EMPTY) begin
              stk_underflow <= 1'b1;
              ie <= 1'b1; sf <= 1'b1; c1 <= 1'b0;
            end
          end
          OP_POP2: if (cmd_idx == 3'd1) begin
            tg[top] <= TAG_EMPTY;
            tg[top_p1] <= TAG_EMPTY;
            top <= top_p2;
            if (tg[top] == TAG_EMPTY || tg[top_p1] == TAG_EMPTY) begin
              stk_underflow <= 1'b1;
              ie <= 1'b1; sf <= 1'b1; c1 <= 1'b0;
            end
          end else begin
            cmd_unhandled <= 1'b1;
          end
          OP_XCHG: begin
            dr[top] <= dr[sel];
            dr[sel] <= dr[top];
            tg[top] <= tg[sel];
            tg[sel] <= tg[top];
          end
          OP_FREE: tg[sel] <= TAG_EMPTY;
          OP_FREP: begin
            tg[sel] <= TAG_EMPTY;
            tg[top] <= TAG_EMPTY;
            top <= top_p1;
          end
          OP_INC: top <= top_p1;
          OP_DEC: top <= top_m1;
          OP_RDSW: begin rd_word <= sw; rd_valid <= 1'b1; end
          OP_RDTW: begin rd_word <= tw; rd_valid <= 1'b1; end
          OP_INIT: begin
            top <= '0;
            ie <= 1'b0; sf <= 1'b0; c1 <= 1'b0;
            for (int k = 0; k < NREG; k++) tg[k] <= TAG_EMPTY;
          end
          default: cmd_unhandled <= 1'b1;
        endcase
      end
    end
  end

  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INC) |=> (top == $past(top) + 3'd1) && $stable(tw));

  a_r5_fault_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PUSH && cmd_fault) |=> $stable(top) && $stable(tw) && !stk_overflow);

  a_r8_free_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_FREE) |=> $stable(top));

  a_r1_init: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INIT) |=> (tw == 16'hFFFF) && (top == '0));

  a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stk_overflow |-> $past(cmd_valid && cmd_op == OP_PUSH && !cmd_fault));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_overflow, stk_underflow, cmd_unhandled}));
endmodule

// File: tb/test_fp_reg_stack.sv
`timescale 1ns/1ps
module test_fp_reg_stack;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_fault = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [2:0] cmd_idx = '0, peek_idx = '0;
  logic [79:0] cmd_data = '0, peek_data;
  logic [1:0] peek_tag;
  logic [15:0] rd_word;
  logic rd_valid, stk_overflow, stk_underflow, cmd_unhandled;

  always #10 clk = ~clk;

  fp_reg_stack i_fp_reg_stack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_fault(cmd_fault),
    .peek_idx(peek_idx), .peek_data(peek_data), .peek_tag(peek_tag),
    .rd_word(rd_word), .rd_valid(rd_valid), .stk_overflow(stk_overflow),
    .stk_underflow(stk_underflow), .cmd_unhandled(cmd_unhandled));

  int total = 0, fails = 0;
  bit done = 0;

  logic [2:0]  mtop = 0;
  logic [1:0]  mtg [8];
  logic [79:0] mdr [8];
  logic mie = 0, msf = 0, mc1 = 0;

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] msw();
    return {2'b00, mtop, 1'b0, mc1, 1'b0, mie, msf, 5'b00000, mie};
  endfunction

  function automatic logic [15:0] mtw();
    logic [15:0] w;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = mtg[k];
    return w;
  endfunction

  task automatic run(string req, logic [3:0] op, logic [2:0] idx, logic [79:0] d, logic f);
    logic eov, eun, euh, erd;
    logic [15:0] erw;
    logic [2:0] a, b;
    logic [1:0] tt;
    logic [79:0] td;
    eov = 0; eun = 0; euh = 0; erd = 0; erw = 0;
    a = mtop + idx;
    case (op)
      4'd1: if (!f) begin
        b = mtop - 1; eov = (mtg[b] != 2'b11);
        mtop = b; mdr[b] = d; mtg[b] = 2'b00;
        if (eov) begin mie = 1; msf = 1; mc1 = 1; end
      end
      4'd2: begin
        eun = (mtg[mtop] == 2'b11); mtg[mtop] = 2'b11; mtop = mtop + 1;
        if (eun) begin mie = 1; msf = 1; mc1 = 0; end
      end
      4'd3: if (idx == 1) begin
        b = mtop + 1;
        eun = (mtg[mtop] == 2'b11) || (mtg[b] == 2'b11);
        mtg[mtop] = 2'b11; mtg[b] = 2'b11; mtop = mtop + 2;
        if (eun) begin mie = 1; msf = 1; mc1 = 0; end
      end else euh = 1;
      4'd4: begin
        td = mdr[mtop]; mdr[mtop] = mdr[a]; mdr[a] = td;
        tt = mtg[mtop]; mtg[mtop] = mtg[a]; mtg[a] = tt;
      end
      4'd5: mtg[a] = 2'b11;
      4'd6: begin mtg[a] = 2'b11; mtg[mtop] = 2'b11; mtop = mtop + 1; end
      4'd7: mtop = mtop + 1;
      4'd8: mtop = mtop - 1;
      4'd9: begin erd = 1; erw = msw(); end
      4'd10: begin erd = 1; erw = mtw(); end
      4'd11: begin mtop = 0; mie = 0; msf = 0; mc1 = 0; for (int k = 0; k < 8; k++) mtg[k] = 2'b11; end
      4'd0: ;
      default: euh = 1;
    endcase
    cmd_valid = 1; cmd_op = op; cmd_idx = idx; cmd_data = d; cmd_fault = f;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0; cmd_fault = 0;
    chk({req, " overflow pulse"}, 80'(stk_overflow), 80'(eov));
    chk({req, " underflow pulse"}, 80'(stk_underflow), 80'(eun));
    chk({req, " unhandled pulse"}, 80'(cmd_unhandled), 80'(euh));
    chk({req, " rd_valid"}, 80'(rd_valid), 80'(erd));
    if (erd) chk({req, " rd_word"}, 80'(rd_word), 80'(erw));
  endtask

  task automatic verify(string req);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] p;
      p = mtop + 3'(i);
      peek_idx = 3'(i);
      #1;
      chk({req, " R2 peek data"}, peek_data, mdr[p]);
      chk({req, " R2 peek tag"}, 80'(peek_tag), 80'(mtg[p]));
    end
    run({req, " R10 status read"}, 4'd9, 0, 0, 0);
    run({req, " R11 tag word read"}, 4'd10, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin mtg[k] = 2'b11; mdr[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    verify("R1 reset");
    for (int k = 0; k < 8; k++) begin
      run("R3 push", 4'd1, 0, {16'hA5A5, 32'(k), 32'hDEAD_0000 + 32'(k)}, 0);
      verify("R3 after push");
    end
    run("R3 push overflow", 4'd1, 0, 80'h7777, 0);
    verify("R3 post overflow");
    run("R5 faulted push on full stack", 4'd1, 0, 80'h1234, 1);
    verify("R5 after fault");
    for (int i = 0; i < 8; i++) begin
      run("R7 exchange", 4'd4, 3'(i), 0, 0);
      verify("R7 after exchange");
    end
    for (int k = 0; k < 9; k++) begin
      run("R9 increment", 4'd7, 0, 0, 0);
      verify("R9 after inc");
    end
    for (int k = 0; k < 10; k++) begin
      run("R9 decrement", 4'd8, 0, 0, 0);
      verify("R9 after dec");
    end
    run("R1 init", 4'd11, 0, 0, 0);
    verify("R1 after init");
    for (int k = 0; k < 3; k++) run("R3 refill", 4'd1, 0, 80'h55 + 80'(k), 0);
    for (int k = 0; k < 5; k++) begin
      run("R4 pop", 4'd2, 0, 0, 0);
      verify("R4 after pop");
    end
    run("R1 init again", 4'd11, 0, 0, 0);
    for (int k = 0; k < 3; k++) run("R3 refill", 4'd1, 0, 80'h900 + 80'(k), 0);
    for (int i = 0; i < 8; i++) begin
      run("R6 double pop index sweep", 4'd3, 3'(i), 0, 0);
      verify("R6 after double pop");
    end
    run("R6 double pop with one empty", 4'd3, 3'd1, 0, 0);
    verify("R6 underflow");
    run("R1 init before free", 4'd11, 0, 0, 0);
    for (int k = 0; k < 8; k++) run("R3 fill", 4'd1, 0, 80'hF00 + 80'(k), 0);
    for (int i = 0; i < 8; i += 2) begin
      run("R8 free", 4'd5, 3'(i), 0, 0);
      verify("R8 after free");
    end
    for (int i = 0; i < 4; i++) begin
      run("R8 free and pop", 4'd6, 3'(i), 0, 0);
      verify("R8 after free-pop");
    end
    for (int op = 12; op < 16; op++) begin
      run("R12 undefined opcode", 4'(op), 3'd2, 80'hBAD, 0);
      verify("R12 after undefined");
    end
    run("R12 nop", 4'd0, 0, 0, 0);
    verify("R12 after nop");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule